// File: doc/BRIEF.md
# Fault Timer and Protection Sequencer

This block sits between the protection comparators of a full-bridge lamp inverter controller and its switching logic. It collects the individual fault flags and runs a fault timer that counts cycles of a timing tick. Each tick stands for one charge and discharge cycle of the external timing capacitor. Once a fault has lasted one cycle, the block pulls its active-low fault status line. Once the fault has lasted fifteen cycles, it latches a halt that tells the bridge to stop switching. If the faults clear before the time-out, the count is discarded and the status line is released.

Faults come from two sources. Faults the controller detects itself are over-voltage, over-current, arcing, hard switching and ignition failure. These also inhibit PWM dimming and oscillator synchronisation. A request from an external circuit runs the timer but leaves dimming and synchronisation alone. The block samples that request only while the lamp current loop is closed, and it ignores the request while it is pulling the status line on account of an internal fault. Driving the enable low clears everything, including a latched halt.

The sequencer has four states. FS_IDLE means no fault and a zero count. FS_COUNT means a fault is present and fewer than one cycle has been counted. FS_ALERT means the status line is pulled. FS_HALT is the latched stop. The transitions are: idle-to-count on any qualified fault; count-to-alert on the tick that completes the first cycle; alert-to-halt on the tick that completes the fifteenth cycle; count-to-idle and alert-to-idle when every qualified fault has cleared. Enable low forces any state to idle. Fault flags pass through one register stage before the sequencer acts on them.

Top module: `prot_fault_seq`

## Requirements
- R1: While en_i is low, on each clock edge the block returns to idle with a zero count: fault_n_o is 1, stop_o is 0 and both inhibits are 0. This clears a latched halt.
- R2: Each internal fault (ov_i, oc_i, arc_i, hs_i) starts the timer. fault_n_o goes to 0 on the first tick_i counted after the fault registers.
- R3: fault_n_o stays 1 until the first counted tick. stop_o stays 0 through the fourteenth counted tick and goes to 1 on the fifteenth.
- R4: After stop_o is 1, it stays 1 with fault_n_o at 0 and both inhibits at 1, even with all faults removed and ticks continuing, until en_i goes low.
- R5: If every qualified fault clears before the halt, the count returns to zero and fault_n_o is released to 1. A later fault again needs fifteen fresh ticks to halt.
- R6: dim_inhibit_o and sync_inhibit_o go to 1 one clock after an internal fault is applied. A fault from ext_fault_i alone leaves both at 0, even while fault_n_o is 0.
- R7: ext_fault_i starts the timer only while loop_closed_i is 1. With the loop open, it has no effect on fault_n_o.
- R8: An ignition failure is sweep_done_i at 1 with lamps_on_i at 0. It behaves as an internal fault. sweep_done_i with lamps_on_i at 1 is not a fault.
- R9: Once fault_n_o has been pulled on account of an internal fault, ext_fault_i is ignored until the block returns to idle. If the internal fault then clears while ext_fault_i is still high, fault_n_o is released.
- R10: tick_i has no effect while no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| en_i | input | 1 | Enable; low clears all state synchronously |
| tick_i | input | 1 | One-clock pulse per completed timing-capacitor cycle |
| ov_i | input | 1 | Over-voltage flag |
| oc_i | input | 1 | Over-current flag |
| arc_i | input | 1 | Arcing one-shot flag |
| hs_i | input | 1 | Hard-switching flag |
| ext_fault_i | input | 1 | Fault request from an external circuit |
| loop_closed_i | input | 1 | Lamp current regulation loop is closed |
| sweep_done_i | input | 1 | Ignition frequency sweep reached its minimum frequency |
| lamps_on_i | input | 1 | Lamps judged ignited |
| fault_n_o | output | 1 | Active-low fault status |
| stop_o | output | 1 | Latched halt of the bridge |
| dim_inhibit_o | output | 1 | Disable PWM dimming |
| sync_inhibit_o | output | 1 | Disable oscillator synchronisation |

## Verification
The hardest situation to reach is the ignoring of the external request. It can only be seen when an internal fault has already pulled the status line, the external request is then raised, and the internal fault is removed while the request stays high. The stimulus reaches this point by driving over-voltage with the loop closed and giving one tick to enter FS_ALERT. Only after that does it raise ext_fault_i, and then it drops over-voltage. The status line must then return to 1 rather than stay pulled. Holding the external request afterwards must start a fresh episode, which proves that the ignore flag clears in FS_IDLE.

// File: rtl/prot_fault_pkg.sv
package prot_fault_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_COUNT = 2'd1,
        FS_ALERT = 2'd2,
        FS_HALT  = 2'd3
    } fs_state_e;

endpackage

// File: rtl/prot_fault_collect.sv
module prot_fault_collect #(
    parameter bit HS_EN = 1'b1
) (
    input  logic clk,
    input  logic en_i,
    input  logic ov_i,
    input  logic oc_i,
    input  logic arc_i,
    input  logic hs_i,
    input  logic sweep_done_i,
    input  logic lamps_on_i,
    input  logic ext_fault_i,
    input  logic loop_closed_i,
    input  logic ignore_ext_i,
    output logic int_fault_o,
    output logic ext_fault_o
);

    logic hs_use;
    logic ign_fail;
    logic int_raw;
    logic ext_raw;

    generate
        if (HS_EN) begin : g_hs
            assign hs_use = hs_i;
        end else begin : g_no_hs
            assign hs_use = 1'b0;
        end
    endgenerate

    // Sweep finished at minimum frequency but lamps never came on
    assign ign_fail = sweep_done_i & ~lamps_on_i;
    assign int_raw  = ov_i | oc_i | arc_i | hs_use | ign_fail;
    // External request only counts with the current loop closed
    assign ext_raw  = ext_fault_i & loop_closed_i & ~ignore_ext_i;

    always_ff @(posedge clk) begin
        if (!en_i) begin
            int_fault_o <= 1'b0;
            ext_fault_o <= 1'b0;
        end else begin
            int_fault_o <= int_raw;
            ext_fault_o <= ext_raw;
        end
    end

endmodule

// File: rtl/prot_cycle_counter.sv
module prot_cycle_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!en_i || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/prot_fault_seq.sv
module prot_fault_seq
    import prot_fault_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int ALERT_AT = 1,
    parameter int HALT_AT  = 15,
    parameter bit HS_EN    = 1'b1
) (
    input  logic clk,
    input  logic en_i,
    input  logic tick_i,
    input  logic ov_i,
    input  logic oc_i,
    input  logic arc_i,
    input  logic hs_i,
    input  logic ext_fault_i,
    input  logic loop_closed_i,
    input  logic sweep_done_i,
    input  logic lamps_on_i,
    output logic fault_n_o,
    output logic stop_o,
    output logic dim_inhibit_o,
    output logic sync_inhibit_o
);

    localparam logic [CNT_W-1:0] ALERT_LAST = CNT_W'(ALERT_AT - 1);
    localparam logic [CNT_W-1:0] HALT_LAST  = CNT_W'(HALT_AT - 1);

    fs_state_e        state_q, state_d;
    logic             int_q, ext_q, any_q;
    logic             self_q, self_d;
    logic             cnt_inc, cnt_clr;
    logic [CNT_W-1:0] cnt;

    prot_fault_collect #(.HS_EN(HS_EN)) u_collect (
        .clk          (clk),
        .en_i         (en_i),
        .ov_i         (ov_i),
        .oc_i         (oc_i),
        .arc_i        (arc_i),
        .hs_i         (hs_i),
        .sweep_done_i (sweep_done_i),
        .lamps_on_i   (lamps_on_i),
        .ext_fault_i  (ext_fault_i),
        .loop_closed_i(loop_closed_i),
        .ignore_ext_i (self_q),
        .int_fault_o  (int_q),
        .ext_fault_o  (ext_q)
    );

    assign any_q   = int_q | ext_q;
    assign cnt_inc = tick_i & any_q &
                     ((state_q == FS_COUNT) || (state_q == FS_ALERT));
    assign cnt_clr = (state_d == FS_IDLE);

    prot_cycle_counter #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .en_i (en_i),
        .clr_i(cnt_clr),
        .inc_i(cnt_inc),
        .cnt_o(cnt)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (any_q) state_d = FS_COUNT;
            end
            FS_COUNT: begin
                if (!any_q)                         state_d = FS_IDLE;
                else if (tick_i && cnt == ALERT_LAST) state_d = FS_ALERT;
            end
            FS_ALERT: begin
                if (!any_q)                        state_d = FS_IDLE;
                else if (tick_i && cnt == HALT_LAST) state_d = FS_HALT;
            end
            FS_HALT: begin
                state_d = FS_HALT;
            end
        endcase
    end

    // Ignore-external flag: set while alerting on an internal fault
    always_comb begin
        self_d = self_q;
        if (state_d == FS_IDLE)
            self_d = 1'b0;
        else if (state_d == FS_ALERT && int_q)
            self_d = 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!en_i) begin
            state_q <= FS_IDLE;
            self_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            self_q  <= self_d;
        end
    end

    // Outputs
    always_comb begin
        fault_n_o      = 1'b1;
        stop_o         = 1'b0;
        dim_inhibit_o  = int_q;
        sync_inhibit_o = int_q;
        unique case (state_q)
            FS_IDLE, FS_COUNT: begin
            end
            FS_ALERT: begin
                fault_n_o = 1'b0;
            end
            FS_HALT: begin
                fault_n_o      = 1'b0;
                stop_o         = 1'b1;
                dim_inhibit_o  = 1'b1;
                sync_inhibit_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/prot_fault_seq_chk.sv
module prot_fault_seq_chk (
    input logic clk,
    input logic en_i,
    input logic tick_i,
    input logic ov_i,
    input logic oc_i,
    input logic arc_i,
    input logic hs_i,
    input logic sweep_done_i,
    input logic lamps_on_i,
    input logic fault_n_o,
    input logic stop_o,
    input logic dim_inhibit_o,
    input logic sync_inhibit_o
);

    p_enable_clears_r1: assert property (@(posedge clk)
        !en_i |=> (fault_n_o && !stop_o && !dim_inhibit_o && !sync_inhibit_o));

    p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!en_i)
        stop_o |=> stop_o);

    p_halt_outputs_r4: assert property (@(posedge clk) disable iff (!en_i)
        stop_o |-> (!fault_n_o && dim_inhibit_o && sync_inhibit_o));

    p_alert_on_tick_r3: assert property (@(posedge clk) disable iff (!en_i)
        $fell(fault_n_o) |-> $past(tick_i));

    p_halt_on_tick_r3: assert property (@(posedge clk) disable iff (!en_i)
        $rose(stop_o) |-> $past(tick_i));

    p_inhibit_cause_r6: assert property (@(posedge clk) disable iff (!en_i)
        ($rose(dim_inhibit_o) && !stop_o) |->
        $past(ov_i || oc_i || arc_i || hs_i || (sweep_done_i && !lamps_on_i)));

endmodule

bind prot_fault_seq prot_fault_seq_chk chk_i (
    .clk           (clk),
    .en_i          (en_i),
    .tick_i        (tick_i),
    .ov_i          (ov_i),
    .oc_i          (oc_i),
    .arc_i         (arc_i),
    .hs_i          (hs_i),
    .sweep_done_i  (sweep_done_i),
    .lamps_on_i    (lamps_on_i),
    .fault_n_o     (fault_n_o),
    .stop_o        (stop_o),
    .dim_inhibit_o (dim_inhibit_o),
    .sync_inhibit_o(sync_inhibit_o)
);

// File: tb/prot_fault_seq_tb_top.sv
`timescale 1ns/1ps
module prot_fault_seq_tb_top;

    logic clk = 1'b0;
    logic en_i = 1'b0, tick_i = 1'b0;
    logic ov_i = 1'b0, oc_i = 1'b0, arc_i = 1'b0, hs_i = 1'b0;
    logic ext_fault_i = 1'b0, loop_closed_i = 1'b0;
    logic sweep_done_i = 1'b0, lamps_on_i = 1'b0;
    logic fault_n_o, stop_o, dim_inhibit_o, sync_inhibit_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prot_fault_seq dut_i (
        .clk           (clk),
        .en_i          (en_i),
        .tick_i        (tick_i),
        .ov_i          (ov_i),
        .oc_i          (oc_i),
        .arc_i         (arc_i),
        .hs_i          (hs_i),
        .ext_fault_i   (ext_fault_i),
        .loop_closed_i (loop_closed_i),
        .sweep_done_i  (sweep_done_i),
        .lamps_on_i    (lamps_on_i),
        .fault_n_o     (fault_n_o),
        .stop_o        (stop_o),
        .dim_inhibit_o (dim_inhibit_o),
        .sync_inhibit_o(sync_inhibit_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic clear_inputs();
        ov_i = 0; oc_i = 0; arc_i = 0; hs_i = 0;
        ext_fault_i = 0; sweep_done_i = 0; lamps_on_i = 0; tick_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        en_i = 1'b0;
        settle(2);
        en_i = 1'b1;
        settle(1);
    endtask

    // R1: reset state
    task automatic t_reset_state();
        en_i = 1'b0;
        settle(3);
        chk("R1", "fault_n in reset", fault_n_o, 1'b1);
        chk("R1", "stop in reset", stop_o, 1'b0);
        chk("R1", "dim inhibit in reset", dim_inhibit_o, 1'b0);
        chk("R1", "sync inhibit in reset", sync_inhibit_o, 1'b0);
        en_i = 1'b1;
        settle(1);
    endtask

    // R10: ticks without fault
    task automatic t_idle_ticks();
        ticks(20);
        chk("R10", "fault_n after idle ticks", fault_n_o, 1'b1);
        chk("R10", "stop after idle ticks", stop_o, 1'b0);
    endtask

    // R3, R4, R1: full count to halt, stickiness, enable clear
    task automatic t_full_count();
        ov_i = 1'b1;
        settle(2);
        chk("R3", "fault_n before first tick", fault_n_o, 1'b1);
        ticks(1);
        chk("R3", "fault_n after first tick", fault_n_o, 1'b0);
        ticks(13);
        chk("R3", "stop after 14 ticks", stop_o, 1'b0);
        ticks(1);
        chk("R3", "stop after 15 ticks", stop_o, 1'b1);
        ov_i = 1'b0;
        settle(3);
        ticks(5);
        chk("R4", "stop held after clear", stop_o, 1'b1);
        chk("R4", "fault_n held in halt", fault_n_o, 1'b0);
        chk("R4", "dim inhibit in halt", dim_inhibit_o, 1'b1);
        chk("R4", "sync inhibit in halt", sync_inhibit_o, 1'b1);
        en_i = 1'b0;
        settle(1);
        chk("R1", "halt cleared by enable", stop_o, 1'b0);
        chk("R1", "fault_n released by enable", fault_n_o, 1'b1);
        en_i = 1'b1;
        settle(3);
        chk("R1", "stays idle after re-enable", stop_o, 1'b0);
    endtask

    // R2, R6: each internal fault source
    task automatic t_each_source();
        for (int s = 0; s < 4; s++) begin
            do_reset();
            case (s)
                0: ov_i  = 1'b1;
                1: oc_i  = 1'b1;
                2: arc_i = 1'b1;
                default: hs_i = 1'b1;
            endcase
            settle(1);
            chk("R6", $sformatf("dim inhibit src %0d", s), dim_inhibit_o, 1'b1);
            chk("R6", $sformatf("sync inhibit src %0d", s), sync_inhibit_o, 1'b1);
            settle(1);
            ticks(1);
            chk("R2", $sformatf("fault_n src %0d", s), fault_n_o, 1'b0);
        end
        do_reset();
    endtask

    // R5: release and fresh count
    task automatic t_release();
        oc_i = 1'b1;
        settle(2);
        ticks(14);
        chk("R5", "alert before release", fault_n_o, 1'b0);
        oc_i = 1'b0;
        settle(3);
        chk("R5", "fault_n released", fault_n_o, 1'b1);
        chk("R5", "inhibit released", dim_inhibit_o, 1'b0);
        oc_i = 1'b1;
        settle(2);
        ticks(14);
        chk("R5", "no halt after 14 fresh ticks", stop_o, 1'b0);
        ticks(1);
        chk("R5", "halt after 15 fresh ticks", stop_o, 1'b1);
        do_reset();
    endtask

    // R7, R6: external request gating
    task automatic t_external();
        loop_closed_i = 1'b0;
        ext_fault_i = 1'b1;
        settle(3);
        ticks(3);
        chk("R7", "ext ignored with loop open", fault_n_o, 1'b1);
        loop_closed_i = 1'b1;
        settle(3);
        ticks(1);
        chk("R7", "ext honoured with loop closed", fault_n_o, 1'b0);
        chk("R6", "ext only leaves dim on", dim_inhibit_o, 1'b0);
        chk("R6", "ext only leaves sync on", sync_inhibit_o, 1'b0);
        ext_fault_i = 1'b0;
        settle(3);
        chk("R7", "ext release", fault_n_o, 1'b1);
        do_reset();
    endtask

    // R8: ignition failure
    task automatic t_ignition();
        sweep_done_i = 1'b1;
        lamps_on_i = 1'b1;
        settle(3);
        ticks(2);
        chk("R8", "no fault with lamps on", fault_n_o, 1'b1);
        chk("R8", "no inhibit with lamps on", dim_inhibit_o, 1'b0);
        lamps_on_i = 1'b0;
        settle(2);
        chk("R8", "ign fail inhibits", dim_inhibit_o, 1'b1);
        ticks(1);
        chk("R8", "ign fail alerts", fault_n_o, 1'b0);
        do_reset();
    endtask

    // R9: external ignored while alerting on an internal fault
    task automatic t_self_ignore();
        loop_closed_i = 1'b1;
        ov_i = 1'b1;
        settle(2);
        ticks(1);
        chk("R9", "internal alert", fault_n_o, 1'b0);
        ext_fault_i = 1'b1;
        settle(2);
        ov_i = 1'b0;
        settle(3);
        chk("R9", "released despite ext high", fault_n_o, 1'b1);
        settle(1);
        ticks(1);
        chk("R9", "fresh ext episode alerts", fault_n_o, 1'b0);
        chk("R9", "fresh ext episode no inhibit", dim_inhibit_o, 1'b0);
        do_reset();
    endtask

    initial begin
        t_reset_state();
        t_idle_ticks();
        t_full_count();
        t_each_source();
        t_release();
        t_external();
        t_ignition();
        t_self_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule